// File: doc/BRIEF.md
# Correlating Two-Level Branch Predictor

This block guesses the direction of conditional branches for an instruction fetch front end. It keeps a short shift register holding the outcomes of the last few resolved branches, globally across all branches. The low-order bits of a branch address pick one entry of a pattern table. Each entry holds one small saturating counter per possible history value, and the current global history chooses which of them is read or trained. Two branches that behave differently depending on what ran just before can therefore be predicted separately inside one entry.

The lookup side is purely combinational: a fetch address presented in a cycle yields a taken or not-taken guess in the same cycle, from the state as it stood at the last clock edge. The training side takes a resolved branch address and its actual outcome. On the next edge it moves the one counter that the pre-shift history selects, and it pushes the outcome into the history. Address bits above the index are not compared, so distant branches with matching low bits share counters.

Top module: `corr_branch_predictor`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every counter holds 01 (weakly not taken), so every address is predicted not taken, and the global history is 00.
- R2: The prediction for an address equals the most significant bit of the counter at the entry given by address bits [3:0] and at the way given by the present global history; it is valid in the same cycle the address is presented.
- R3: A valid update moves the selected counter one step: up on a taken outcome, down on a not-taken one. A weakly-taken counter (10) predicts not taken after a single not-taken outcome, and a strongly-taken counter (11) still predicts taken after one.
- R4: Counters saturate: a taken outcome leaves 11 at 11 and a not-taken outcome leaves 00 at 00.
- R5: A valid update changes only the one counter chosen by its index and the pre-update history; the other three ways of that entry and every other entry keep their values.
- R6: Each valid update shifts its outcome into history bit 0 and moves the old bit 0 to bit 1 (1 = taken, 0 = not taken), so history 01 means the older branch fell through and the newer one was taken. The counter write uses the history from before that shift.
- R7: Address bits above bit 3 take no part in lookup or training: addresses with equal bits [3:0] read and train the same counters.
- R8: When a lookup and an update occur in the same cycle, the lookup returns the prediction from the state before that update.
- R9: When the update-valid input is low, neither the counters nor the history change, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W (32) | Address of the branch being fetched |
| pred_taken | output | 1 | Same-cycle guess for pred_pc: 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W (32) | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch: 1 = taken |

## Verification
The guess is combinational from registered state, so it is due in the very cycle its address is applied, while a training request shows its effect only in predictions made after the next rising edge. The bench therefore changes inputs at the falling edge and samples the guess 2 ns later, which is still before the edge that commits any update driven in that cycle; a check of a training effect is always placed one cycle after the training request. Same-cycle lookup and update is checked in that same sampling window, where the result must still reflect the old counter.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    BR_FALL = 1'b0,
    BR_JUMP = 1'b1
  } br_dir_e;

  function automatic br_dir_e dir_of(input logic msb);
    return msb ? BR_JUMP : BR_FALL;
  endfunction

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= outcome;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
      end
    end
  endgenerate

  assign hist_o = hist_q;

endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             up,
  output logic [CTR_W-1:0] nxt
);

  localparam logic [CTR_W-1:0] TOP = '1;
  localparam logic [CTR_W-1:0] BOT = '0;

  always_comb begin
    if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
    else    nxt = (cur == BOT) ? cur : cur - 1'b1;
  end

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  localparam int SLOT_W = IDX_W + HIST_W,
  localparam int SLOTS  = 1 << SLOT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [HIST_W-1:0]  rd_way,
  output logic [CTR_W-1:0]   rd_ctr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [HIST_W-1:0]  wr_way,
  input  logic               wr_up,
  output logic [SLOTS*CTR_W-1:0] table_flat
);

  localparam logic [CTR_W-1:0] WEAK_FALL = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0]  ctr_q [SLOTS];
  logic [SLOT_W-1:0] rd_slot;
  logic [SLOT_W-1:0] wr_slot;
  logic [CTR_W-1:0]  wr_cur;
  logic [CTR_W-1:0]  wr_nxt;

  assign rd_slot = {rd_idx, rd_way};
  assign wr_slot = {wr_idx, wr_way};
  assign rd_ctr  = ctr_q[rd_slot];
  assign wr_cur  = ctr_q[wr_slot];

  bp_sat_step #(.CTR_W(CTR_W)) u_step (
    .cur (wr_cur),
    .up  (wr_up),
    .nxt (wr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) ctr_q[s] <= WEAK_FALL;
    end else if (wr_en) begin
      ctr_q[wr_slot] <= wr_nxt;
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_flat
      assign table_flat[g*CTR_W +: CTR_W] = ctr_q[g];
    end
  endgenerate

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  import bp_pkg::*;

  localparam int SLOTS = 1 << (IDX_W + HIST_W);

  logic [HIST_W-1:0]      ghist;
  logic [CTR_W-1:0]       look_ctr;
  logic [SLOTS*CTR_W-1:0] table_flat;
  br_dir_e                look_dir;
  logic                   unused_hi;

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .hist_o   (ghist)
  );

  bp_pattern_table #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W),
    .CTR_W  (CTR_W)
  ) u_pht (
    .clk        (clk),
    .rst        (rst),
    .rd_idx     (pred_pc[IDX_W-1:0]),
    .rd_way     (ghist),
    .rd_ctr     (look_ctr),
    .wr_en      (upd_valid),
    .wr_idx     (upd_pc[IDX_W-1:0]),
    .wr_way     (ghist),
    .wr_up      (upd_taken),
    .table_flat (table_flat)
  );

  assign look_dir   = dir_of(look_ctr[CTR_W-1]);
  assign pred_taken = (look_dir == BR_JUMP);

  assign unused_hi = ^{pred_pc[PC_W-1:IDX_W], upd_pc[PC_W-1:IDX_W]};

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  localparam int SLOT_W = IDX_W + HIST_W,
  localparam int SLOTS  = 1 << SLOT_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   upd_valid,
  input logic [IDX_W-1:0]       upd_idx,
  input logic                   upd_taken,
  input logic [HIST_W-1:0]      ghist,
  input logic [SLOTS*CTR_W-1:0] table_flat
);

  localparam logic [CTR_W-1:0] WEAK_FALL = {1'b0, {(CTR_W-1){1'b1}}};

  function automatic logic [CTR_W-1:0] step_ref(input logic [CTR_W-1:0] c,
                                                 input logic up);
    if (up) return (&c) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  logic                   seen;
  logic                   v_q;
  logic                   t_q;
  logic [SLOT_W-1:0]      slot_q;
  logic [SLOTS*CTR_W-1:0] flat_q;
  logic [SLOTS-1:0]       chg;

  always_ff @(posedge clk) begin
    seen   <= !rst;
    v_q    <= upd_valid;
    t_q    <= upd_taken;
    slot_q <= {upd_idx, ghist};
    flat_q <= table_flat;
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_chg
      assign chg[g] = table_flat[g*CTR_W +: CTR_W] != flat_q[g*CTR_W +: CTR_W];
    end
  endgenerate

  // R1: reset state
  assert_reset_hist_R1: assert property (@(posedge clk)
    rst |=> (ghist == '0));
  assert_reset_table_R1: assert property (@(posedge clk)
    rst |=> (table_flat == {SLOTS{WEAK_FALL}}));

  // R6: shift of the outcome into bit 0
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (ghist == HIST_W'({$past(ghist), $past(upd_taken)})));

  // R9: idle cycles leave state alone
  assert_idle_hist_R9: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(ghist));
  assert_idle_table_R9: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(table_flat));

  // R3, R4: the trained counter takes one saturating step
  assert_ctr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (seen && v_q) |->
      (table_flat[slot_q*CTR_W +: CTR_W] ==
       step_ref(flat_q[slot_q*CTR_W +: CTR_W], t_q)));

  // R5: at most one counter moves per cycle
  assert_one_slot_R5: assert property (@(posedge clk) disable iff (rst)
    seen |-> ($countones(chg) <= 1));

endmodule

bind corr_branch_predictor bp_checker #(
  .IDX_W  (IDX_W),
  .HIST_W (HIST_W),
  .CTR_W  (CTR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_valid  (upd_valid),
  .upd_idx    (upd_pc[IDX_W-1:0]),
  .upd_taken  (upd_taken),
  .ghist      (ghist),
  .table_flat (table_flat)
);

// File: tb/sim_corr_branch_predictor.sv
`timescale 1ns/1ps
module sim_corr_branch_predictor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int          mdl [16][4];
  logic [1:0]  mhist;

  always #4 clk = ~clk;

  corr_branch_predictor u0 (
    .clk        (clk),
    .rst        (rst),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
  );

  typedef struct packed {
    logic [7:0] ppc;
    logic       v;
    logic [7:0] upc;
    logic       t;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{8'h03, 1'b1, 8'h03, 1'b1}, '{8'h03, 1'b1, 8'h03, 1'b1},
    '{8'h03, 1'b1, 8'h13, 1'b0}, '{8'h13, 1'b1, 8'h0A, 1'b1},
    '{8'h0A, 1'b1, 8'h0A, 1'b1}, '{8'h0A, 1'b0, 8'h0A, 1'b0},
    '{8'h0A, 1'b1, 8'h0A, 1'b1}, '{8'h0A, 1'b1, 8'h0A, 1'b1},
    '{8'hFA, 1'b1, 8'h05, 1'b0}, '{8'h05, 1'b1, 8'h05, 1'b0},
    '{8'h05, 1'b1, 8'h05, 1'b0}, '{8'h03, 1'b1, 8'h0C, 1'b1},
    '{8'h0C, 1'b1, 8'h0C, 1'b0}, '{8'h0C, 1'b1, 8'h0C, 1'b1},
    '{8'h0C, 1'b1, 8'h0C, 1'b0}, '{8'h0C, 1'b1, 8'h0C, 1'b1},
    '{8'h0C, 1'b0, 8'h00, 1'b1}, '{8'h0C, 1'b1, 8'h0F, 1'b1},
    '{8'h0F, 1'b1, 8'h0F, 1'b1}, '{8'h0F, 1'b1, 8'h0F, 1'b1},
    '{8'h0F, 1'b1, 8'h01, 1'b0}, '{8'h0F, 1'b0, 8'h0F, 1'b0}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, pred_pc, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++)
      for (int w = 0; w < 4; w++) mdl[i][w] = 1;
    mhist = 2'b00;
  endtask

  task automatic model_train(input logic [31:0] pc, input logic t);
    int c;
    c = mdl[pc[3:0]][mhist];
    if (t && c < 3) c++;
    else if (!t && c > 0) c--;
    mdl[pc[3:0]][mhist] = c;
    mhist = {mhist[0], t};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one cycle: drive, compare against the model before the edge, then train
  task automatic step_model(input logic [31:0] ppc, input logic v,
                            input logic [31:0] upc, input logic t,
                            input string tag);
    @(negedge clk);
    pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
    #2;
    check(tag, pred_taken, (mdl[ppc[3:0]][mhist] >= 2) ? 1'b1 : 1'b0);
    if (v) model_train(upc, t);
  endtask

  task automatic upd(input logic [31:0] pc, input logic t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    model_train(pc, t);
  endtask

  task automatic probe(input logic [31:0] pc, input logic exp, input string tag);
    @(negedge clk);
    upd_valid = 1'b0; pred_pc = pc;
    #2;
    check(tag, pred_taken, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();

    // R1: every entry weakly not taken after reset
    for (int i = 0; i < 16; i++) probe(32'(i), 1'b0, "R1 reset");

    // R2: vector table against the independent model
    for (int k = 0; k < NV; k++)
      step_model({24'h0, VEC[k].ppc}, VEC[k].v, {24'h0, VEC[k].upc}, VEC[k].t,
                 "R2 table");

    // R1 again after a trained state
    do_reset();
    for (int i = 0; i < 16; i++) probe(32'(i), 1'b0, "R1 re-reset");

    // R5 / R6: ways chosen by history, history order 01 = older NT, newer T
    upd(32'h2, 1'b0);
    upd(32'h2, 1'b1);
    upd(32'h7, 1'b1);
    probe(32'h7, 1'b0, "R5 other way untouched");
    upd(32'h9, 1'b0);
    upd(32'h9, 1'b1);
    probe(32'h7, 1'b1, "R6 history 01 selects trained way");
    probe(32'h9, 1'b0, "R5 neighbour way untouched");

    // R8: same-cycle lookup sees pre-update counter (7/01 = 10)
    step_model(32'h7, 1'b1, 32'h7, 1'b0, "R8 same cycle");
    upd(32'h9, 1'b0);
    upd(32'h9, 1'b1);
    // R3: weak taken flipped by a single not-taken
    probe(32'h7, 1'b0, "R3 weak flip");

    // R9: invalid updates must not train or shift
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h7; upd_taken = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h7; upd_taken = 1'b1;
    probe(32'h7, 1'b0, "R9 idle ignored");

    // R4: floor saturation
    do_reset();
    upd(32'h0, 1'b0);
    upd(32'h0, 1'b0);
    upd(32'h0, 1'b0);
    upd(32'h0, 1'b1);
    upd(32'h5, 1'b0);
    upd(32'h5, 1'b0);
    probe(32'h0, 1'b0, "R4 floor");

    // R4 / R3: ceiling saturation, strong survives one not-taken
    do_reset();
    upd(32'h6, 1'b1);
    upd(32'h6, 1'b1);
    upd(32'h6, 1'b1);
    upd(32'h6, 1'b1);
    upd(32'h6, 1'b1);
    upd(32'h6, 1'b0);
    upd(32'h4, 1'b1);
    upd(32'h4, 1'b1);
    probe(32'h6, 1'b1, "R3 strong holds");
    upd(32'h6, 1'b0);
    upd(32'h4, 1'b1);
    upd(32'h4, 1'b1);
    probe(32'h6, 1'b0, "R4 ceiling");

    // R7: upper address bits ignored
    upd(32'h5A5A_1236, 1'b1);
    probe(32'h0000_0006, 1'b1, "R7 alias low");
    probe(32'hFFFF_FFF6, 1'b1, "R7 alias high");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule